// File: doc/BRIEF.md
# Seven-Tap Weighted Averaging Filter

This block smooths a stream of signed conversion results. Each time the input strobe is high it accepts one sample. It forms a weighted sum of that sample and the six samples accepted before it. The newest sample counts twice and each older one counts once, so the weights add up to eight. The sum is divided by eight with an arithmetic right shift of three bits, which rounds toward negative infinity. The result is registered and presented with its own strobe one clock later.

The filter stays silent after reset until its window is full. The first six accepted samples only fill the history, and the seventh accepted sample produces the first valid output. When the input strobe is low, nothing moves: the history does not shift, the output strobe stays low and the last result is held. The internal sum has enough headroom that full-scale input never wraps.

Top module: `tap7_smoother`

## Requirements
- R1: For each accepted sample x, the result equals floor((2*x + h1 + h2 + h3 + h4 + h5 + h6) / 8), where h1..h6 are the six samples accepted before x (h1 most recent). The division rounds toward negative infinity, so a sum of -1 yields -1.
- R2: `out_valid` is high in the cycle after an accepted sample whose window is full, and is low in any cycle whose previous cycle had `in_valid` low.
- R3: After reset, the first six accepted samples produce no output strobe, and every accepted sample from the seventh onward produces exactly one.
- R4: While `in_valid` is low, `in_sample` is ignored: the history does not advance and `out_sample` keeps its last value.
- R5: Synchronous reset (`rst` high at a rising edge) drives `out_valid` and `out_sample` to zero and restarts the six-sample fill.
- R6: Full-scale inputs do not overflow. Seven samples of the largest positive value give that value, and seven of the most negative value give that value.
- R7: An accepted sample contributes with weight 2/8 to its own result and 1/8 to each of the next six results, and not at all after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result strobe, one cycle after the accepted sample |
| out_sample | output | DATA_W | Signed filtered result |

## Verification
A history stage that is out of order or stuck corrupts results within at most seven accepted samples. The bench shows this with an impulse that walks through every tap and with ramps whose results depend on each tap's value. A wrong fill count shows up at the strobe right away: a result arrives during the first six samples, or is missing at the seventh. A history that moves while the strobe is low changes the next result after a gap. A shift that truncates toward zero instead of rounding down shows on the first small negative sum.

// File: rtl/tap7_pkg.sv
package tap7_pkg;
    // number of older samples held behind the newest one
    localparam int HIST_LEN   = 6;
    // total weight 2 + HIST_LEN = 8 -> divide by shifting right
    localparam int SCALE_SH   = 3;
    // headroom above the sample width for the weighted sum
    localparam int GUARD_BITS = 3;
endpackage

// File: rtl/tap7_history.sv
module tap7_history #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           shift_en,
    input  logic signed [DATA_W-1:0]       din,
    output logic [DEPTH-1:0][DATA_W-1:0]   taps_o
);
    logic [DEPTH-1:0][DATA_W-1:0] taps_d;
    logic [DEPTH-1:0][DATA_W-1:0] taps_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_comb taps_d[i] = shift_en ? din : taps_q[i];
            end else begin : g_body
                always_comb taps_d[i] = shift_en ? taps_q[i-1] : taps_q[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) taps_q <= '0;
        else     taps_q <= taps_d;
    end

    assign taps_o = taps_q;
endmodule

// File: rtl/tap7_sum.sv
module tap7_sum #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 6,
    parameter int ACC_W  = 15
) (
    input  logic signed [DATA_W-1:0]       newest,
    input  logic [DEPTH-1:0][DATA_W-1:0]   taps,
    output logic signed [ACC_W-1:0]        sum_o
);
    localparam int EXT_W = ACC_W - DATA_W;

    logic signed [ACC_W-1:0] acc_d;

    always_comb begin
        acc_d = {{EXT_W{newest[DATA_W-1]}}, newest} <<< 1;
        for (int i = 0; i < DEPTH; i++) begin
            acc_d = acc_d + {{EXT_W{taps[i][DATA_W-1]}}, taps[i]};
        end
    end

    assign sum_o = acc_d;
endmodule

// File: rtl/tap7_fill.sv
module tap7_fill #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step && (cnt_q != CNT_W'(DEPTH))) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/tap7_smoother.sv
module tap7_smoother
    import tap7_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int ACC_W = DATA_W + GUARD_BITS;

    typedef struct packed {
        logic                     valid;
        logic signed [DATA_W-1:0] sample;
    } out_state_t;

    logic [HIST_LEN-1:0][DATA_W-1:0] taps;
    logic signed [ACC_W-1:0]         wsum;
    logic signed [ACC_W-1:0]         scaled;
    logic                            window_full;
    out_state_t                      st_d;
    out_state_t                      st_q;

    tap7_history #(.DATA_W(DATA_W), .DEPTH(HIST_LEN)) u_history (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_sample),
        .taps_o   (taps)
    );

    tap7_sum #(.DATA_W(DATA_W), .DEPTH(HIST_LEN), .ACC_W(ACC_W)) u_sum (
        .newest (in_sample),
        .taps   (taps),
        .sum_o  (wsum)
    );

    tap7_fill #(.DEPTH(HIST_LEN)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .step   (in_valid),
        .full_o (window_full)
    );

    assign scaled = wsum >>> SCALE_SH;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid && window_full;
        if (in_valid) st_d.sample = scaled[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_sample = st_q.sample;
endmodule

// File: rtl/tap7_smoother_chk.sv
module tap7_smoother_chk #(
    parameter int DATA_W = 12
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_sample,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_sample
);
    // accepted samples since reset, saturating at seven
    logic [2:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)                         seen_q <= '0;
        else if (in_valid && seen_q != 3'd7) seen_q <= seen_q + 3'd1;
    end

    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R2

    AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q == 3'd7)); // R3

    AST_FULL_WINDOW_FIRES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seen_q >= 3'd6) |=> out_valid); // R3

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(out_sample)); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sample == '0)); // R5

    logic unused_in;
    assign unused_in = ^in_sample;
endmodule

bind tap7_smoother tap7_smoother_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/tap7_smoother_bench.sv
module tap7_smoother_bench;
    localparam int DATA_W   = 12;
    localparam int CLK_HALF = 5;
    localparam int MAXV     = (1 << (DATA_W - 1)) - 1;
    localparam int MINV     = -(1 << (DATA_W - 1));

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_sample = '0;
    logic                     out_valid;
    logic signed [DATA_W-1:0] out_sample;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    exp_q[$];
    string tag_q[$];
    int    hist[6];
    int    fill = 0;
    int    last_exp = 0;
    string cur_tag = "R1";

    always #(CLK_HALF) clk = ~clk;

    tap7_smoother #(.DATA_W(DATA_W)) u_tap7_smoother (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        foreach (hist[i]) hist[i] = 0;
        fill = 0;
    endtask

    // driver: presents one sample and queues the result the requirements predict
    task automatic send(input int s);
        int acc;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = DATA_W'(s);
        acc = 2 * s;
        foreach (hist[i]) acc += hist[i];
        if (fill == 6) begin
            exp_q.push_back(acc >>> 3);
            tag_q.push_back(cur_tag);
            last_exp = acc >>> 3;
        end
        for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
        if (fill < 6) fill++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = DATA_W'(k * 731 + 5);
        end
    endtask

    task automatic do_reset();
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        model_clear();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: every strobe must match the oldest queued expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", int'(out_valid), 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(out_sample) == e, t, int'(out_sample), e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R2", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5: reset state
        check(out_valid == 1'b0, "R5", int'(out_valid), 0);
        check(out_sample == '0, "R5", int'(out_sample), 0);

        // R3: six fill samples give no strobe, seventh gives one
        cur_tag = "R3";
        for (int i = 1; i <= 7; i++) send(i * 10);
        cur_tag = "R1";
        for (int i = 0; i < 10; i++) send(i * 37 - 150);
        idle(2);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);

        // R4: idle gap with junk on the data pins keeps result and history
        idle(3);
        check(out_valid == 1'b0, "R4", int'(out_valid), 0);
        check(int'(out_sample) == last_exp, "R4", int'(out_sample), last_exp);
        cur_tag = "R4";
        send(100); idle(2); send(-60); idle(1); send(7);
        idle(2);

        // R1: floor rounding on small negative sums
        do_reset();
        cur_tag = "R3";
        for (int i = 0; i < 6; i++) send(0);
        cur_tag = "R1";
        send(-1); send(0); send(3); send(-5);
        idle(2);

        // R7: impulse response walks through every tap
        do_reset();
        for (int i = 0; i < 6; i++) send(0);
        cur_tag = "R7";
        send(64);
        for (int i = 0; i < 8; i++) send(0);
        idle(2);

        // R6: full-scale positive and negative
        cur_tag = "R6";
        for (int i = 0; i < 7; i++) send(MAXV);
        idle(2);
        check(int'(out_sample) == MAXV, "R6", int'(out_sample), MAXV);
        for (int i = 0; i < 7; i++) send(MINV);
        idle(2);
        check(int'(out_sample) == MINV, "R6", int'(out_sample), MINV);

        // R5: mid-run reset restarts the fill count
        cur_tag = "R5";
        send(11); send(22);
        do_reset();
        check(out_valid == 1'b0, "R5", int'(out_valid), 0);
        check(out_sample == '0, "R5", int'(out_sample), 0);
        for (int i = 0; i < 9; i++) send(i * 100 - 400);
        idle(3);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule